// File: doc/BRIEF.md
# USB Receive Endpoint Control and Status

This block holds the control and status state of one USB device OUT endpoint that owns a two-packet receive buffer. The packet engine reports each finished packet with a strobe and flags a CRC or bit-stuff fault on it. The CPU sees one 8-bit register. It reads receive-ready and the data-error flag from it, raises or drops a stall request, clears the stalled flag, clears the data toggle and flushes packets. A separate read-complete strobe tells the block that software has drained the packet at the head of the buffer.

Buffer occupancy is kept by a state machine with four states. `BUF_EMPTY` holds no packet. `BUF_ONE` holds one packet and shows it as ready. `BUF_TWO` has both slots full. `BUF_RELOAD` holds one packet that has not yet been shown: receive-ready stays low for that one cycle. The transitions are:
- fill: `BUF_EMPTY` to `BUF_ONE`, and `BUF_ONE` to `BUF_TWO`.
- drain: `BUF_ONE` to `BUF_EMPTY`.
- swap: `BUF_TWO` to `BUF_RELOAD` on a release. `BUF_ONE` to `BUF_RELOAD` when a release and a new packet arrive in the same cycle.
- present: `BUF_RELOAD` to `BUF_ONE`.
- refill: `BUF_RELOAD` to `BUF_TWO` when a packet arrives.

The transfer-mode input selects bulk (0) or isochronous (1). In isochronous mode the data-error flag is reported, and the stall request and data toggle have no effect.

Top module: `usb_rx_ep_ctl`

## Requirements
- R1: After reset, the register reads 0x00, `data_toggle`, `stall_hs` and `fifo_ptr_rst` are 0, and the buffer is empty. Bit 0 is receive-ready, and bits 2 and 1 always read 0.
- R2: A `pkt_done` strobe is accepted whenever a slot is free. It makes bit 0 read 1 from the next cycle. A packet that arrives while both slots are full is dropped.
- R3: A `rd_done` strobe while receive-ready is 1 releases the head packet. If no packet remains, bit 0 reads 0. If the other slot (or a packet accepted in the same cycle) holds a packet, bit 0 reads 0 for exactly one cycle and then 1.
- R4: Writing 1 to bit 4 while receive-ready is 1 discards exactly one packet, with the same ready behaviour as R3, and pulses `fifo_ptr_rst` for one cycle. Emptying a full buffer takes two such writes.
- R5: A flush write or `rd_done` while receive-ready is 0 changes nothing: no `fifo_ptr_rst` pulse, and the buffer state is kept.
- R6: `data_toggle` inverts on each packet accepted in bulk mode. It is unchanged by packets accepted in isochronous mode and by dropped packets.
- R7: Writing 1 to bit 7 clears `data_toggle`, and writing 0 there leaves it alone. Bits 7 and 4 always read 0.
- R8: Bit 5 is a read/write stall request. `stall_hs` is 1 exactly when bit 5 is 1 and `iso_mode` is 0.
- R9: Bit 6 is set by `stall_sent` while `stall_hs` is 1. A register write with bit 6 at 0 clears it, and a write with bit 6 at 1 leaves it unchanged. A `stall_sent` strobe while `stall_hs` is 0 does not set it.
- R10: Bit 3 reads 1 only in isochronous mode, while receive-ready is 1 and the head packet was received with `crc_err` or `stuff_err`. It reads 0 whenever receive-ready is 0 and always in bulk mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read value |
| rd_done | input | 1 | Software has drained the head packet |
| iso_mode | input | 1 | 1 = isochronous, 0 = bulk |
| pkt_done | input | 1 | Packet-complete strobe from the packet engine |
| crc_err | input | 1 | CRC fault on the packet, valid with pkt_done |
| stuff_err | input | 1 | Bit-stuff fault on the packet, valid with pkt_done |
| stall_sent | input | 1 | A STALL handshake went out on the bus |
| rx_ready | output | 1 | Receive-ready, same as register bit 0 |
| data_toggle | output | 1 | Expected data toggle of the next packet |
| stall_hs | output | 1 | Answer OUT tokens with STALL |
| fifo_ptr_rst | output | 1 | One-cycle pulse to reset the FIFO read pointer |

## Verification
The buffer is driven with these patterns:
- single packets, to check fill and drain on their own.
- back-to-back packets, including a third one that has to be dropped.
- a release in the same cycle as an arrival.
- flushes of a full buffer and of an empty one.

The one-cycle ready gap is what separates a swap from a drain. The toggle value after the dropped packet shows whether acceptance is decided from the full state. Error packets alternate with clean ones in isochronous mode, so a flag tied to the head slot can be told apart from a sticky flag. Switching to bulk mode while a faulty packet is pending then shows that the flag is masked.

// File: rtl/usb_rx_ep_pkg.sv
package usb_rx_ep_pkg;

    localparam int REG_W       = 8;
    localparam int CLR_TGL_BIT = 7;
    localparam int STALLED_BIT = 6;
    localparam int STALL_BIT   = 5;
    localparam int FLUSH_BIT   = 4;
    localparam int DERR_BIT    = 3;
    localparam int READY_BIT   = 0;
    localparam int NUM_SLOTS   = 2;
    localparam int SLOT_IDX_W  = $clog2(NUM_SLOTS);

    typedef enum logic [1:0] {
        BUF_EMPTY  = 2'd0,
        BUF_ONE    = 2'd1,
        BUF_TWO    = 2'd2,
        BUF_RELOAD = 2'd3
    } buf_state_e;

endpackage

// File: rtl/rx_buf_fsm.sv
module rx_buf_fsm
    import usb_rx_ep_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pkt_done,
    input  logic pkt_err,
    input  logic release_req,
    input  logic flush_req,
    output logic rx_ready,
    output logic head_err,
    output logic pkt_acc,
    output logic ptr_rst
);

    buf_state_e state_q, state_d;
    logic [NUM_SLOTS-1:0] err_q;
    logic [SLOT_IDX_W-1:0] wr_slot;
    logic rel_ok;

    // Outputs and slot selection
    always_comb begin
        rx_ready = (state_q == BUF_ONE) || (state_q == BUF_TWO);
        pkt_acc  = pkt_done && (state_q != BUF_TWO);
        rel_ok   = release_req && rx_ready;
        head_err = err_q[0];
        if (state_q == BUF_EMPTY || rel_ok) begin
            wr_slot = '0;
        end else begin
            wr_slot = SLOT_IDX_W'(1);
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUF_EMPTY:  state_d = pkt_done ? BUF_ONE : BUF_EMPTY;
            BUF_ONE: begin
                unique case ({rel_ok, pkt_done})
                    2'b11:   state_d = BUF_RELOAD;
                    2'b10:   state_d = BUF_EMPTY;
                    2'b01:   state_d = BUF_TWO;
                    default: state_d = BUF_ONE;
                endcase
            end
            BUF_TWO:    state_d = rel_ok ? BUF_RELOAD : BUF_TWO;
            BUF_RELOAD: state_d = pkt_done ? BUF_TWO : BUF_ONE;
            default:    state_d = BUF_EMPTY;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= BUF_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    // Per-slot error flags and read-pointer reset pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q   <= '0;
            ptr_rst <= 1'b0;
        end else begin
            ptr_rst <= flush_req && rx_ready;
            if (rel_ok) begin
                err_q <= {1'b0, err_q[NUM_SLOTS-1:1]};
            end
            if (pkt_acc) begin
                err_q[wr_slot] <= pkt_err;
            end
        end
    end

    // R3
    reload_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_ready && release_req && (state_q == BUF_TWO)) |=> !rx_ready);

    // R3
    reload_show_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == BUF_RELOAD) |=> rx_ready);

    // R5
    flush_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_ready && flush_req) |=> !ptr_rst);

    // R2
    fill_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == BUF_EMPTY && pkt_done) |=> rx_ready);

endmodule

// File: rtl/rx_ep_flags.sv
module rx_ep_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic iso_mode,
    input  logic pkt_acc,
    input  logic clr_toggle,
    input  logic wr_en,
    input  logic wr_stall,
    input  logic wr_stalled,
    input  logic stall_sent,
    output logic data_toggle,
    output logic stall_req,
    output logic stalled,
    output logic stall_hs
);

    always_comb begin
        stall_hs = stall_req && !iso_mode;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_toggle <= 1'b0;
            stall_req   <= 1'b0;
            stalled     <= 1'b0;
        end else begin
            if (clr_toggle) begin
                data_toggle <= 1'b0;
            end else if (pkt_acc && !iso_mode) begin
                data_toggle <= !data_toggle;
            end
            if (wr_en) begin
                stall_req <= wr_stall;
            end
            if (stall_sent && stall_hs) begin
                stalled <= 1'b1;
            end else if (wr_en && !wr_stalled) begin
                stalled <= 1'b0;
            end
        end
    end

    // R6
    toggle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pkt_acc && !clr_toggle) |=> $stable(data_toggle));

    // R8
    stall_iso_chk: assert property (@(posedge clk) disable iff (!rst_n)
        iso_mode |-> !stall_hs);

    // R9
    stalled_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!stalled && !(stall_sent && stall_hs)) |=> !stalled);

endmodule

// File: rtl/usb_rx_ep_ctl.sv
module usb_rx_ep_ctl
    import usb_rx_ep_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             rd_done,
    input  logic             iso_mode,
    input  logic             pkt_done,
    input  logic             crc_err,
    input  logic             stuff_err,
    input  logic             stall_sent,
    output logic             rx_ready,
    output logic             data_toggle,
    output logic             stall_hs,
    output logic             fifo_ptr_rst
);

    logic flush_req;
    logic clr_toggle;
    logic head_err;
    logic pkt_acc;
    logic stall_req;
    logic stalled;
    logic unused_wbits;

    assign flush_req    = reg_wr && reg_wdata[FLUSH_BIT];
    assign clr_toggle   = reg_wr && reg_wdata[CLR_TGL_BIT];
    assign unused_wbits = ^{reg_wdata[DERR_BIT:0]};

    rx_buf_fsm u_buf (
        .clk         (clk),
        .rst_n       (rst_n),
        .pkt_done    (pkt_done),
        .pkt_err     (crc_err || stuff_err),
        .release_req (rd_done || flush_req),
        .flush_req   (flush_req),
        .rx_ready    (rx_ready),
        .head_err    (head_err),
        .pkt_acc     (pkt_acc),
        .ptr_rst     (fifo_ptr_rst)
    );

    rx_ep_flags u_flags (
        .clk         (clk),
        .rst_n       (rst_n),
        .iso_mode    (iso_mode),
        .pkt_acc     (pkt_acc),
        .clr_toggle  (clr_toggle),
        .wr_en       (reg_wr),
        .wr_stall    (reg_wdata[STALL_BIT]),
        .wr_stalled  (reg_wdata[STALLED_BIT]),
        .stall_sent  (stall_sent),
        .data_toggle (data_toggle),
        .stall_req   (stall_req),
        .stalled     (stalled),
        .stall_hs    (stall_hs)
    );

    always_comb begin
        reg_rdata              = '0;
        reg_rdata[READY_BIT]   = rx_ready;
        reg_rdata[DERR_BIT]    = rx_ready && iso_mode && head_err;
        reg_rdata[STALL_BIT]   = stall_req;
        reg_rdata[STALLED_BIT] = stalled;
    end

    // R10
    derr_bulk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !iso_mode |-> !reg_rdata[DERR_BIT]);

    // R10
    derr_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rdata[READY_BIT] |-> !reg_rdata[DERR_BIT]);

    // R7
    action_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rdata[CLR_TGL_BIT] && !reg_rdata[FLUSH_BIT]);

endmodule

// File: tb/usb_rx_ep_ctl_tb.sv
module usb_rx_ep_ctl_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       rd_done = 1'b0;
    logic       iso_mode = 1'b0;
    logic       pkt_done = 1'b0;
    logic       crc_err = 1'b0;
    logic       stuff_err = 1'b0;
    logic       stall_sent = 1'b0;
    logic       rx_ready;
    logic       data_toggle;
    logic       stall_hs;
    logic       fifo_ptr_rst;

    int    n_checks = 0;
    int    n_fails  = 0;
    bit    iso_next = 1'b0;
    bit    finished = 1'b0;
    logic [11:0] exp_q[$];
    string       tag_q[$];

    always #4 clk = !clk;

    usb_rx_ep_ctl dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .rd_done(rd_done), .iso_mode(iso_mode),
        .pkt_done(pkt_done), .crc_err(crc_err), .stuff_err(stuff_err),
        .stall_sent(stall_sent), .rx_ready(rx_ready), .data_toggle(data_toggle),
        .stall_hs(stall_hs), .fifo_ptr_rst(fifo_ptr_rst)
    );

    // Monitor: pops and compares expectations away from the active edge
    always @(negedge clk) begin
        while (exp_q.size() > 0) begin
            logic [11:0] e;
            logic [11:0] a;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            a = {reg_rdata, rx_ready, stall_hs, fifo_ptr_rst, data_toggle};
            n_checks++;
            if (a !== e) begin
                n_fails++;
                $display("FAIL %s rdata/ready/stall_hs/ptr_rst/toggle actual=%h/%b/%b/%b/%b expected=%h/%b/%b/%b/%b",
                         t, a[11:4], a[3], a[2], a[1], a[0], e[11:4], e[3], e[2], e[1], e[0]);
            end
        end
    end

    // Driver: one clock cycle of stimulus, inputs applied after the negedge
    task automatic tick(input bit wr, input logic [7:0] wd, input bit pkt,
                        input bit ce, input bit se, input bit rd, input bit ss);
        @(negedge clk);
        #2;
        reg_wr = wr; reg_wdata = wd; pkt_done = pkt; crc_err = ce;
        stuff_err = se; rd_done = rd; stall_sent = ss; iso_mode = iso_next;
        @(posedge clk);
        #1;
        reg_wr = 1'b0; reg_wdata = '0; pkt_done = 1'b0; crc_err = 1'b0;
        stuff_err = 1'b0; rd_done = 1'b0; stall_sent = 1'b0;
    endtask

    task automatic expect_st(input logic [7:0] rd, input bit sh, input bit pr,
                             input bit tg, input string tag);
        exp_q.push_back({rd, rd[0], sh, pr, tg});
        tag_q.push_back(tag);
    endtask

    task automatic idle();
        tick(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    endtask
    task automatic pkt(input bit ce, input bit se);
        tick(1'b0, 8'h00, 1'b1, ce, se, 1'b0, 1'b0);
    endtask
    task automatic rel();
        tick(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    endtask
    task automatic wr(input logic [7:0] d);
        tick(1'b1, d, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    endtask

    initial begin
        #(200000 * 8);
        if (!finished) begin
            n_fails++;
            $display("FAIL watchdog expired");
            report();
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        expect_st(8'h00, 0, 0, 0, "R1 reset");
        @(negedge clk);
        #2 rst_n = 1'b1;

        // Fill, overflow, swap and drain (bulk)
        pkt(0, 0);  expect_st(8'h01, 0, 0, 1, "R2 first packet");
        pkt(0, 0);  expect_st(8'h01, 0, 0, 0, "R6 second packet toggles");
        pkt(0, 0);  expect_st(8'h01, 0, 0, 0, "R2 R6 third packet dropped");
        rel();      expect_st(8'h00, 0, 0, 0, "R3 swap gap");
        idle();     expect_st(8'h01, 0, 0, 0, "R3 next packet shown");
        rel();      expect_st(8'h00, 0, 0, 0, "R3 drain");
        rel();      expect_st(8'h00, 0, 0, 0, "R5 rd_done ignored");
        wr(8'h10);  expect_st(8'h00, 0, 0, 0, "R5 flush ignored");
        idle();     expect_st(8'h00, 0, 0, 0, "R5 still empty");

        // Release in the same cycle as an arrival
        pkt(0, 0);  expect_st(8'h01, 0, 0, 1, "R2 fill");
        tick(1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
        expect_st(8'h00, 0, 0, 0, "R3 swap with arrival");
        idle();     expect_st(8'h01, 0, 0, 0, "R3 arrival shown");

        // Flush of a full buffer takes two writes
        pkt(0, 0);  expect_st(8'h01, 0, 0, 1, "R2 full");
        wr(8'h10);  expect_st(8'h00, 0, 1, 1, "R4 first flush");
        idle();     expect_st(8'h01, 0, 0, 1, "R4 one packet left");
        wr(8'h10);  expect_st(8'h00, 0, 1, 1, "R4 second flush");
        idle();     expect_st(8'h00, 0, 0, 1, "R4 empty, pulse ended");

        // Toggle clear
        pkt(0, 0);  expect_st(8'h01, 0, 0, 0, "R6 toggle");
        pkt(0, 0);  expect_st(8'h01, 0, 0, 1, "R6 toggle");
        wr(8'h00);  expect_st(8'h01, 0, 0, 1, "R7 zero write keeps toggle");
        wr(8'h80);  expect_st(8'h01, 0, 0, 0, "R7 toggle cleared");
        rel();      expect_st(8'h00, 0, 0, 0, "R3 swap");
        idle();     expect_st(8'h01, 0, 0, 0, "R3 shown");
        rel();      expect_st(8'h00, 0, 0, 0, "R3 drained");

        // Stall request and stalled flag
        wr(8'h20);  expect_st(8'h20, 1, 0, 0, "R8 stall request");
        tick(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
        expect_st(8'h60, 1, 0, 0, "R9 stalled set");
        wr(8'h60);  expect_st(8'h60, 1, 0, 0, "R9 write 1 keeps stalled");
        wr(8'h20);  expect_st(8'h20, 1, 0, 0, "R9 write 0 clears stalled");
        iso_next = 1'b1;
        idle();     expect_st(8'h20, 0, 0, 0, "R8 no stall in iso");
        tick(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
        expect_st(8'h20, 0, 0, 0, "R9 stall_sent ignored");
        wr(8'h00);  expect_st(8'h00, 0, 0, 0, "R8 stall dropped");

        // Data error in isochronous mode
        pkt(1, 0);  expect_st(8'h09, 0, 0, 0, "R10 crc error, R6 no iso toggle");
        pkt(0, 0);  expect_st(8'h09, 0, 0, 0, "R10 head still faulty");
        rel();      expect_st(8'h00, 0, 0, 0, "R10 clears with ready");
        idle();     expect_st(8'h01, 0, 0, 0, "R10 clean packet");
        rel();      expect_st(8'h00, 0, 0, 0, "R3 drained");
        pkt(0, 1);  expect_st(8'h09, 0, 0, 0, "R10 stuff error");
        iso_next = 1'b0;
        idle();     expect_st(8'h01, 0, 0, 0, "R10 masked in bulk");
        rel();      expect_st(8'h00, 0, 0, 0, "R3 drained");
        idle();

        @(negedge clk);
        #1;
        finished = 1'b1;
        report();
        $finish;
    end

endmodule